// File: doc/BRIEF.md
# Iterative Factorial, LCM and Primality Unit

A multi-cycle arithmetic coprocessor that sits beside a small accumulator datapath. The host raises `start_i` for one cycle with an operation code and one or two 8-bit unsigned operands. The unit then works through the request with clocked loops. It uses a shift-add multiplier, a shift-subtract divider and a subtract-until-equal greatest-common-divisor engine. No constant table is involved. The result comes back with a one-cycle `done_o` pulse.

Factorial and least common multiple give a 16-bit value, split into a high byte and a low byte. The host writes these into two neighbouring words of its result memory. The primality test gives a single flag, which the host copies into its equal flag. Operand fetch and the memory writes belong to the host, not to this unit.

Top module: `iter_math_unit`

## Requirements
- R1: When `start_i` is high while `busy_o` is low, `op_i`, `a_i` and `b_i` are captured at that clock edge. `busy_o` is high from the next cycle up to the cycle before `done_o`. `busy_o` is low in the cycle where `done_o` is high.
- R2: A `start_i` pulse while `busy_o` is high is ignored. Changes on `op_i`, `a_i` and `b_i` after capture have no effect on the running operation.
- R3: `done_o` is high for exactly one cycle per accepted request. `res_hi_o`, `res_lo_o` and `prime_o` take their new values in that cycle and hold them until the next `done_o`.
- R4: Op code 2'b00 computes the factorial of `a_i[2:0]` as a 16-bit value: bits 15:8 on `res_hi_o`, bits 7:0 on `res_lo_o`. The inputs 0 and 1 both give 1, and `a_i[7:3]` is ignored.
- R5: Op code 2'b01 computes the 16-bit least common multiple of `a_i` and `b_i` (unsigned), with the same byte split as R4. If either operand is 0 the result is 0.
- R6: Op codes 2'b10 and 2'b11 test `a_i` (unsigned) for primality: `prime_o` is 1 exactly when `a_i` is prime. The values 0 and 1 are not prime.
- R7: A primality request leaves `res_hi_o` and `res_lo_o` unchanged. A factorial or LCM request leaves `prime_o` unchanged.
- R8: No request keeps `busy_o` high for more than 300 consecutive cycles.
- R9: While `rst_ni` is low, `busy_o`, `done_o`, `res_hi_o`, `res_lo_o` and `prime_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| op_i | input | 2 | 00 factorial, 01 LCM, 1x primality |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand (LCM only) |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_hi_o | output | 8 | Result bits 15:8 |
| res_lo_o | output | 8 | Result bits 7:0 |
| prime_o | output | 1 | Primality flag |

## Verification
The assertions assume the host treats `start_i` as meaningful only while `busy_o` is low. They also assume the host reads results only in the `done_o` cycle or later, so they check the handshake and hold behaviour rather than arithmetic values. The stimulus keeps to that contract. It also pokes `start_i` mid-run on long LCM requests and scrambles the operand inputs after every capture, to show that both are ignored. Arithmetic is covered by exhaustive factorial and primality sweeps, LCM corner pairs (zero, equal, coprime, worst-case subtraction chains) and random LCM pairs.

// File: rtl/imu_pkg.sv
`timescale 1ns/1ps
package imu_pkg;
  localparam int unsigned DW = 8;
  localparam logic [1:0] OP_FACT = 2'b00;
  localparam logic [1:0] OP_LCM  = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FACT,
    ST_GCD,
    ST_DIV,
    ST_MUL,
    ST_PRIME,
    ST_DONE
  } state_e;
endpackage

// File: rtl/imu_mul.sv
`timescale 1ns/1ps
// Shift-add multiplier, one multiplier bit per cycle, product truncated to AW
module imu_mul #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic          done_o,
  output logic [AW-1:0] p_o
);
  localparam int unsigned CW = $clog2(BW + 1);

  logic [AW-1:0] mcand_q, acc_q;
  logic [BW-1:0] mplier_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      acc_q    <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        acc_q    <= '0;
        mcand_q  <= a_i;
        mplier_q <= b_i;
        cnt_q    <= CW'(BW);
      end else if (cnt_q != '0) begin
        if (mplier_q[0]) acc_q <= acc_q + mcand_q;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q - 1'b1;
        done_o   <= (cnt_q == CW'(1));
      end
    end
  end

  assign p_o = acc_q;
endmodule

// File: rtl/imu_div.sv
`timescale 1ns/1ps
// Restoring shift-subtract divider, one quotient bit per cycle; den must be nonzero
module imu_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0] rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]   trial, diff;

  assign trial = {rem_q, quo_q[W-1]};
  assign diff  = trial - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        den_q <= den_i;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        if (!diff[W]) begin
          rem_q <= diff[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q  <= cnt_q - 1'b1;
        done_o <= (cnt_q == CW'(1));
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/imu_gcd.sv
`timescale 1ns/1ps
// Subtract-until-equal GCD; both operands must be nonzero
module imu_gcd #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         done_o,
  output logic [W-1:0] g_o
);
  logic [W-1:0] x_q, y_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        x_q   <= a_i;
        y_q   <= b_i;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (x_q == y_q) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end else if (x_q > y_q) begin
          x_q <= x_q - y_q;
        end else begin
          y_q <= y_q - x_q;
        end
      end
    end
  end

  assign g_o = x_q;
endmodule

// File: rtl/iter_math_unit.sv
`timescale 1ns/1ps
module iter_math_unit #(
  parameter int unsigned DW = imu_pkg::DW,
  parameter int unsigned FW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] res_hi_o,
  output logic [DW-1:0] res_lo_o,
  output logic          prime_o
);
  import imu_pkg::*;
  localparam int unsigned RW = 2 * DW;

  state_e        state_q;
  logic [DW-1:0] a_q, b_q, dv_q;
  logic [FW-1:0] n_q, k_q;
  logic [RW-1:0] acc_q, res_q;
  logic          wait_q, op_prime_q, is_prime_q, prime_q, done_q;

  logic          mul_go, mul_done, div_go, div_done, gcd_go, gcd_done;
  logic [RW-1:0] mul_a, mul_p, sq;
  logic [DW-1:0] mul_b, div_den, div_quo, div_rem, gcd_g;
  logic          sq_gt;

  // trial divisor squared against the candidate
  assign sq    = RW'(dv_q) * RW'(dv_q);
  assign sq_gt = sq > RW'(a_q);

  assign mul_go  = !wait_q && (state_q == ST_FACT || state_q == ST_MUL);
  assign mul_a   = (state_q == ST_FACT) ? acc_q : RW'(div_quo);
  assign mul_b   = (state_q == ST_FACT) ? DW'(k_q) : b_q;
  assign div_go  = !wait_q && (state_q == ST_DIV || (state_q == ST_PRIME && !sq_gt));
  assign div_den = (state_q == ST_PRIME) ? dv_q : gcd_g;
  assign gcd_go  = !wait_q && (state_q == ST_GCD);

  imu_mul #(.AW(RW), .BW(DW)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(mul_go), .a_i(mul_a), .b_i(mul_b),
    .done_o(mul_done), .p_o(mul_p)
  );

  imu_div #(.W(DW)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(div_go), .num_i(a_q), .den_i(div_den),
    .done_o(div_done), .quo_o(div_quo), .rem_o(div_rem)
  );

  imu_gcd #(.W(DW)) u_gcd (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(gcd_go), .a_i(a_q), .b_i(b_q),
    .done_o(gcd_done), .g_o(gcd_g)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      a_q        <= '0;
      b_q        <= '0;
      dv_q       <= '0;
      n_q        <= '0;
      k_q        <= '0;
      acc_q      <= '0;
      res_q      <= '0;
      wait_q     <= 1'b0;
      op_prime_q <= 1'b0;
      is_prime_q <= 1'b0;
      prime_q    <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          a_q        <= a_i;
          b_q        <= b_i;
          wait_q     <= 1'b0;
          op_prime_q <= op_i[1];
          if (op_i[1]) begin
            dv_q <= DW'(2);
            if (a_i < DW'(2)) begin
              is_prime_q <= 1'b0;
              state_q    <= ST_DONE;
            end else begin
              state_q <= ST_PRIME;
            end
          end else if (op_i == OP_FACT) begin
            acc_q   <= RW'(1);
            k_q     <= FW'(2);
            n_q     <= a_i[FW-1:0];
            state_q <= (a_i[FW-1:0] < FW'(2)) ? ST_DONE : ST_FACT;
          end else if (a_i == '0 || b_i == '0) begin
            acc_q   <= '0;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_GCD;
          end
        end
        ST_FACT: begin
          if (!wait_q) wait_q <= 1'b1;
          else if (mul_done) begin
            acc_q  <= mul_p;
            wait_q <= 1'b0;
            if (k_q == n_q) state_q <= ST_DONE;
            else            k_q     <= k_q + 1'b1;
          end
        end
        ST_GCD: begin
          if (!wait_q) wait_q <= 1'b1;
          else if (gcd_done) begin
            wait_q  <= 1'b0;
            state_q <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (!wait_q) wait_q <= 1'b1;
          else if (div_done) begin
            wait_q  <= 1'b0;
            state_q <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (!wait_q) wait_q <= 1'b1;
          else if (mul_done) begin
            acc_q   <= mul_p;
            wait_q  <= 1'b0;
            state_q <= ST_DONE;
          end
        end
        ST_PRIME: begin
          if (!wait_q) begin
            if (sq_gt) begin
              is_prime_q <= 1'b1;
              state_q    <= ST_DONE;
            end else begin
              wait_q <= 1'b1;
            end
          end else if (div_done) begin
            wait_q <= 1'b0;
            if (div_rem == '0) begin
              is_prime_q <= 1'b0;
              state_q    <= ST_DONE;
            end else begin
              dv_q <= dv_q + 1'b1;
            end
          end
        end
        ST_DONE: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
          if (op_prime_q) prime_q <= is_prime_q;
          else            res_q   <= acc_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign res_hi_o = res_q[RW-1:DW];
  assign res_lo_o = res_q[DW-1:0];
  assign prime_o  = prime_q;
endmodule

// File: rtl/imu_chk.sv
`timescale 1ns/1ps
module imu_chk #(
  parameter int unsigned DW      = 8,
  parameter int unsigned MAX_LAT = 300
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] res_hi_o,
  input logic [DW-1:0] res_lo_o,
  input logic          prime_o
);
  logic [15:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (busy_o) lat_q <= lat_q + 1'b1;
    else             lat_q <= '0;
  end

  // R1
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R1
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R1
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(res_hi_o) && $stable(res_lo_o) && $stable(prime_o)));

  // R8
  lat_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q <= 16'(MAX_LAT));

  // R9
  always_comb begin
    if (!rst_ni) begin
      rst_state_chk: assert (!busy_o && !done_o && res_hi_o == '0 && res_lo_o == '0 && !prime_o);
    end
  end
endmodule

bind iter_math_unit imu_chk #(.DW(DW), .MAX_LAT(300)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .prime_o(prime_o)
);

// File: tb/sim_iter_math_unit.sv
`timescale 1ns/1ps
module sim_iter_math_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [7:0] a_i = '0, b_i = '0;
  logic       busy_o, done_o, prime_o;
  logic [7:0] res_hi_o, res_lo_o;

  int checks = 0, fails = 0;
  bit mon_en = 1'b0;

  // behavioural model state
  bit    inflight = 1'b0, ign = 1'b0, p_prime = 1'b0;
  int    lat = 0, e_res = 0, h_res = 0;
  bit    e_prime = 1'b0, h_prime = 1'b0;
  string p_tag = "";

  always #2.5 clk = ~clk;

  iter_math_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .busy_o(busy_o), .done_o(done_o), .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .prime_o(prime_o)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_fact(int n);
    int r = 1;
    for (int i = 2; i <= n; i++) r *= i;
    return r;
  endfunction

  function automatic int ref_lcm(int a, int b);
    int x = a, y = b, t;
    if (a == 0 || b == 0) return 0;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return (a / x) * b;
  endfunction

  function automatic bit ref_prime(int a);
    if (a < 2) return 1'b0;
    for (int d = 2; d * d <= a; d++) if (a % d == 0) return 1'b0;
    return 1'b1;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (mon_en) begin
      int cur;
      cur = {res_hi_o, res_lo_o};
      if (inflight) begin
        if (done_o) begin
          chk(!busy_o, "R1 busy low at done", busy_o, 0);
          chk(lat <= 300, "R8 latency", lat, 300);
          if (p_prime) begin
            chk(prime_o == e_prime, p_tag, prime_o, e_prime);
            chk(cur == h_res, "R7 bytes kept on prime op", cur, h_res);
            h_prime = e_prime;
          end else begin
            chk(cur == e_res, p_tag, cur, e_res);
            chk(prime_o == h_prime, "R7 flag kept on arith op", prime_o, h_prime);
            h_res = e_res;
          end
          if (ign) chk(cur == h_res && prime_o == h_prime, "R2 poke ignored", cur, h_res);
          inflight = 1'b0;
        end else begin
          chk(busy_o, "R1 busy during run", busy_o, 1);
          chk(cur == h_res && prime_o == h_prime, "R3 outputs held", cur, h_res);
          lat++;
        end
      end else begin
        chk(!busy_o && !done_o, "R3 idle no busy/done", {busy_o, done_o}, 0);
        chk(cur == h_res && prime_o == h_prime, "R3 outputs held idle", cur, h_res);
      end
      if (start_i && !inflight) begin
        p_prime  = op_i[1];
        e_prime  = ref_prime(a_i);
        inflight = 1'b1;
        ign      = 1'b0;
        lat      = 0;
        if (op_i[1])           p_tag = "R6 prime";
        else if (op_i == 2'b00) p_tag = "R4 factorial";
        else                    p_tag = "R5 lcm";
        e_res = (op_i == 2'b00) ? ref_fact(a_i & 8'h07) : ref_lcm(a_i, b_i);
      end else if (start_i && inflight) begin
        ign = 1'b1;
      end
    end
  end

  task automatic run_op(logic [1:0] op, logic [7:0] a, logic [7:0] b, bit poke);
    @(posedge clk); #1;
    op_i = op; a_i = a; b_i = b; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    // R2: scramble inputs after capture
    op_i = 2'($urandom); a_i = 8'($urandom); b_i = 8'($urandom);
    if (poke) begin
      repeat (3) @(posedge clk);
      #1 start_i = 1'b1;
      @(posedge clk); #1 start_i = 1'b0;
    end
    do @(negedge clk); while (!done_o);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    int la[10] = '{0, 5, 12, 255, 1, 255, 255, 17, 128, 200};
    int lb[10] = '{5, 0, 18, 1, 255, 254, 255, 13, 2, 150};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(!busy_o, "R9 busy", busy_o, 0);
    chk(!done_o, "R9 done", done_o, 0);
    chk({res_hi_o, res_lo_o} == 0, "R9 result", {res_hi_o, res_lo_o}, 0);
    chk(!prime_o, "R9 prime", prime_o, 0);
    rst_ni = 1'b1;
    mon_en = 1'b1;

    // R4 factorial sweep with junk upper bits
    for (int n = 0; n < 8; n++) run_op(2'b00, 8'({$urandom} << 3) | 8'(n), 8'($urandom), 1'b0);
    // R6 exhaustive primality
    for (int v = 0; v < 256; v++) run_op(2'b10, 8'(v), 8'($urandom), 1'b0);
    for (int v = 250; v < 256; v++) run_op(2'b11, 8'(v), 8'h00, 1'b0);
    // R5 corner pairs
    for (int i = 0; i < 10; i++) run_op(2'b01, 8'(la[i]), 8'(lb[i]), 1'b0);
    // R2 start pulses while busy
    run_op(2'b01, 8'd255, 8'd1, 1'b1);
    run_op(2'b01, 8'd36, 8'd60, 1'b1);
    run_op(2'b01, 8'd9, 8'd9, 1'b1);
    // R7 alternating kinds
    run_op(2'b00, 8'd5, 8'd0, 1'b0);
    run_op(2'b10, 8'd97, 8'd0, 1'b0);
    run_op(2'b01, 8'd14, 8'd21, 1'b0);
    run_op(2'b10, 8'd91, 8'd0, 1'b0);
    // R5 random pairs
    for (int i = 0; i < 120; i++) run_op(2'b01, 8'($urandom), 8'($urandom), 1'b0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule